// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small multicycle load/store processor. Its step sequence is not fixed in next-state gates. A micro-program counter walks through a writable micro-instruction store. Each micro-instruction is a bundle of datapath control values plus a two-bit next-address field. After the decode step, an opcode-indexed dispatch table selects where each instruction's micro-routine starts. On every clock the block presents the control word of the current step on registered outputs. The datapath, register file, shared memory and ALU sit outside it.

Both the micro-instruction store and the dispatch table can be rewritten through one write port. This lets instruction behaviour change after reset, for example to alter a step, to add an opcode or to retire an opcode. The port takes effect only while the sequencer is halted. Releasing halt restarts execution at the fetch step.

Top module: `ucseq_top`

## Requirements
- R1: While reset is high, and in the cycle that follows it, `upc` is 0 and `mem_write`, `reg_write`, `pc_write`, `ir_load` and `illegal` are low. The first clock edge with reset low presents the fetch step at `upc` 0.
- R2: A micro-instruction is 12 bits, MSB first: pc_write[11], ir_load[10], reg_write[9], reg_src[8:7], alu_op[6:5], alu_src[4], mem_addr_sel[3], mem_write[2], next[1:0]. The outputs show the fields of the step at `upc`, and there is one step per clock. Encodings: alu_op 00 add, 01 subtract, 10 pass; reg_src 00 ALU, 01 memory; alu_src 1 immediate; mem_addr_sel 0 PC, 1 computed address.
- R3: A next field of 00 moves `upc` to `upc`+1.
- R4: A next field of 01 dispatches on `opcode`. The entry is {valid at bit 5, start address in bits 4:0}, and `upc` becomes that start address. The default program has fetch at address 0 (pc_write, ir_load) and decode at address 1 (all controls low, next 01).
- R5: A next field of 10 or 11 returns `upc` to 0.
- R6: A dispatch on an opcode without a valid entry returns to `upc` 0. `illegal` is high for exactly that one fetch cycle.
- R7: Default add (opcode 0) uses addresses 2 then 3. Default subtract (opcode 1) uses 4 (alu_op 01) then 5. The second step writes the register from the ALU, so each takes four steps.
- R8: Default load (opcode 2) takes five steps. Step 6 computes base plus immediate (alu_src 1). Step 7 reads memory at the computed address (mem_addr_sel 1). Step 8 writes the register from memory (reg_write, reg_src 01).
- R9: Default store (opcode 3) takes four steps. Step 9 computes the address (alu_src 1). Step 10 asserts mem_write with mem_addr_sel 1. No register write follows.
- R10: Default branch (opcode 4, step 11: alu_op 01, pc_write) and jump (opcode 5, step 12: alu_op 10, pc_write) take three steps. Opcodes 6 to 15 have no entry.
- R11: Fetch addresses the shared memory by PC (mem_addr_sel 0). Data steps use the computed address in other cycles.
- R12: While `halt` is high, `upc` is 0 and all controls are low. After `halt` falls, the next edge presents fetch at `upc` 0.
- R13: A write takes effect only when `wr_en` and `halt` are both high. `wr_addr[5]`=0 writes the store word `wr_addr[4:0]` with `wr_data`. `wr_addr[5]`=1 writes dispatch entry `wr_addr[3:0]` with `wr_data[5:0]`. Writes while running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Stops sequencing and enables the write port |
| opcode | input | 4 | Opcode of the fetched instruction |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Bit 5 selects table, low bits index |
| wr_data | input | 12 | Micro-instruction or dispatch entry |
| upc | output | 5 | Current micro-PC |
| mem_write | output | 1 | Memory write enable |
| mem_addr_sel | output | 1 | Memory address from PC (0) or ALU (1) |
| alu_src | output | 1 | ALU second operand is immediate |
| alu_op | output | 2 | ALU operation |
| reg_src | output | 2 | Register write data source |
| reg_write | output | 1 | Register file write enable |
| ir_load | output | 1 | Instruction register load |
| pc_write | output | 1 | PC write enable |
| illegal | output | 1 | Undispatched opcode seen |

## Verification
Each step's control word and `upc` appear one rising edge after the sequencer chooses that step's address. Fetch therefore appears at the first edge after reset or halt is released. Decode appears at the next edge, and the dispatched step appears at the edge after the one that ends decode. `illegal` rises together with the fetch that follows a failed dispatch. The driver changes inputs at falling edges and queues the expected step words before the edge that produces them. The monitor pops one item 2 ns after each rising edge. This keeps every comparison aligned with the cycle in which that step's output is due.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

  typedef enum logic [1:0] {
    NX_SEQ   = 2'b00,
    NX_DISP  = 2'b01,
    NX_FETCH = 2'b10,
    NX_RSVD  = 2'b11
  } nxt_e;

  typedef struct packed {
    logic       pc_write;
    logic       ir_load;
    logic       reg_write;
    logic [1:0] reg_src;
    logic [1:0] alu_op;
    logic       alu_src;
    logic       mem_addr_sel;
    logic       mem_write;
    nxt_e       nxt;
  } uinst_t;

  localparam int UI_W = $bits(uinst_t);

  // Power-up microprogram, one word per micro-address
  function automatic uinst_t boot_uinst(int a);
    uinst_t u;
    u = '0;
    u.nxt = NX_SEQ;
    case (a)
      0:  begin u.pc_write = 1'b1; u.ir_load = 1'b1; end
      1:  u.nxt = NX_DISP;
      2:  ;
      3:  begin u.reg_write = 1'b1; u.nxt = NX_FETCH; end
      4:  u.alu_op = 2'b01;
      5:  begin u.reg_write = 1'b1; u.nxt = NX_FETCH; end
      6:  u.alu_src = 1'b1;
      7:  u.mem_addr_sel = 1'b1;
      8:  begin u.reg_write = 1'b1; u.reg_src = 2'b01; u.nxt = NX_FETCH; end
      9:  u.alu_src = 1'b1;
      10: begin u.mem_write = 1'b1; u.mem_addr_sel = 1'b1; u.nxt = NX_FETCH; end
      11: begin u.alu_op = 2'b01; u.pc_write = 1'b1; u.nxt = NX_FETCH; end
      12: begin u.alu_op = 2'b10; u.pc_write = 1'b1; u.nxt = NX_FETCH; end
      default: ;
    endcase
    return u;
  endfunction

  // Power-up dispatch start address per opcode, -1 when unmapped
  function automatic int boot_target(int op);
    case (op)
      0: return 2;
      1: return 4;
      2: return 6;
      3: return 9;
      4: return 11;
      5: return 12;
      default: return -1;
    endcase
  endfunction

endpackage

// File: rtl/ucseq_store.sv
module ucseq_store
  import ucseq_pkg::*;
#(
  parameter int UA_W = 5
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            we,
  input  logic [UA_W-1:0] waddr,
  input  uinst_t          wdata,
  input  logic [UA_W-1:0] raddr,
  output uinst_t          rdata
);
  localparam int DEPTH = 1 << UA_W;

  uinst_t mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = boot_uinst(i);
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // synchronous read with output register reset, block RAM style
  always_ff @(posedge clk) begin
    if (clr) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/ucseq_dispatch.sv
module ucseq_dispatch
  import ucseq_pkg::*;
#(
  parameter int OPC_W = 4,
  parameter int UA_W  = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [OPC_W-1:0] waddr,
  input  logic [UA_W:0]    wdata,
  input  logic [OPC_W-1:0] opcode,
  output logic             hit,
  output logic [UA_W-1:0]  target
);
  localparam int NOPC = 1 << OPC_W;

  logic [UA_W:0] tbl [NOPC];

  initial begin
    for (int i = 0; i < NOPC; i++) begin
      if (boot_target(i) < 0) tbl[i] = '0;
      else                    tbl[i] = {1'b1, UA_W'(boot_target(i))};
    end
  end

  always_ff @(posedge clk) begin
    if (we) tbl[waddr] <= wdata;
  end

  assign hit    = tbl[opcode][UA_W];
  assign target = tbl[opcode][UA_W-1:0];
endmodule

// File: rtl/ucseq_next.sv
module ucseq_next
  import ucseq_pkg::*;
#(
  parameter int UA_W = 5
) (
  input  logic            run,
  input  logic [1:0]      nxt,
  input  logic [UA_W-1:0] upc,
  input  logic            hit,
  input  logic [UA_W-1:0] target,
  output logic [UA_W-1:0] nxt_upc,
  output logic            bad_op
);
  always_comb begin
    nxt_upc = '0;
    bad_op  = 1'b0;
    if (run) begin
      case (nxt)
        NX_SEQ:  nxt_upc = upc + UA_W'(1);
        NX_DISP: begin
          nxt_upc = hit ? target : '0;
          bad_op  = !hit;
        end
        default: nxt_upc = '0;
      endcase
    end
  end
endmodule

// File: rtl/ucseq_top.sv
module ucseq_top
  import ucseq_pkg::*;
#(
  parameter int OPC_W = 4,
  parameter int UA_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt,
  input  logic [OPC_W-1:0] opcode,
  input  logic             wr_en,
  input  logic [UA_W:0]    wr_addr,
  input  logic [UI_W-1:0]  wr_data,
  output logic [UA_W-1:0]  upc,
  output logic             mem_write,
  output logic             mem_addr_sel,
  output logic             alu_src,
  output logic [1:0]       alu_op,
  output logic [1:0]       reg_src,
  output logic             reg_write,
  output logic             ir_load,
  output logic             pc_write,
  output logic             illegal
);
  logic            stop;
  logic            run_q;
  logic [UA_W-1:0] upc_q;
  logic            illegal_q;
  uinst_t          ui_q;
  logic [1:0]      cur_nxt;
  logic            hit;
  logic [UA_W-1:0] target;
  logic [UA_W-1:0] nxt_upc;
  logic            bad_op;
  logic            wr_ok;

  assign stop    = rst | halt;
  assign wr_ok   = wr_en & halt & !rst;
  assign cur_nxt = ui_q.nxt;

  ucseq_store #(.UA_W(UA_W)) u_store (
    .clk   (clk),
    .clr   (stop),
    .we    (wr_ok & !wr_addr[UA_W]),
    .waddr (wr_addr[UA_W-1:0]),
    .wdata (uinst_t'(wr_data)),
    .raddr (nxt_upc),
    .rdata (ui_q)
  );

  ucseq_dispatch #(.OPC_W(OPC_W), .UA_W(UA_W)) u_disp (
    .clk    (clk),
    .we     (wr_ok & wr_addr[UA_W]),
    .waddr  (wr_addr[OPC_W-1:0]),
    .wdata  (wr_data[UA_W:0]),
    .opcode (opcode),
    .hit    (hit),
    .target (target)
  );

  ucseq_next #(.UA_W(UA_W)) u_next (
    .run     (run_q),
    .nxt     (cur_nxt),
    .upc     (upc_q),
    .hit     (hit),
    .target  (target),
    .nxt_upc (nxt_upc),
    .bad_op  (bad_op)
  );

  always_ff @(posedge clk) begin
    if (stop) begin
      run_q     <= 1'b0;
      upc_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      run_q     <= 1'b1;
      upc_q     <= nxt_upc;
      illegal_q <= bad_op;
    end
  end

  assign upc          = upc_q;
  assign illegal      = illegal_q;
  assign mem_write    = ui_q.mem_write;
  assign mem_addr_sel = ui_q.mem_addr_sel;
  assign alu_src      = ui_q.alu_src;
  assign alu_op       = ui_q.alu_op;
  assign reg_src      = ui_q.reg_src;
  assign reg_write    = ui_q.reg_write;
  assign ir_load      = ui_q.ir_load;
  assign pc_write     = ui_q.pc_write;
endmodule

// File: rtl/ucseq_chk.sv
module ucseq_chk #(
  parameter int UA_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            halt,
  input logic            run,
  input logic [1:0]      nxt,
  input logic [UA_W-1:0] upc,
  input logic            mem_write,
  input logic            reg_write,
  input logic            pc_write,
  input logic            ir_load,
  input logic            illegal
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (upc == '0 && !mem_write && !reg_write && !pc_write && !ir_load && !illegal)); // R1

  AST_RESET_FETCH: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !halt) |=> (upc == '0)); // R1

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && nxt == 2'b00 && !halt) |=> (upc == $past(upc) + UA_W'(1))); // R3

  AST_RET_FETCH: assert property (@(posedge clk) disable iff (rst)
    (run && nxt[1] && !halt) |=> (upc == '0)); // R5

  AST_ILLEGAL_AT_FETCH: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (upc == '0)); // R6

  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (rst)
    illegal |=> !illegal); // R6

  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (rst)
    halt |=> (upc == '0 && !mem_write && !reg_write && !pc_write && !ir_load)); // R12

  AST_HALT_RESTART: assert property (@(posedge clk) disable iff (rst)
    ($past(halt) && !halt) |=> (upc == '0)); // R12
endmodule

bind ucseq_top ucseq_chk #(.UA_W(UA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .halt      (halt),
  .run       (run_q),
  .nxt       (cur_nxt),
  .upc       (upc),
  .mem_write (mem_write),
  .reg_write (reg_write),
  .pc_write  (pc_write),
  .ir_load   (ir_load),
  .illegal   (illegal)
);

// File: tb/tb_ucseq_top.sv
`timescale 1ns/1ps
module tb_ucseq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halt = 1'b0;
  logic [3:0]  opcode = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [4:0]  upc;
  logic        mem_write, mem_addr_sel, alu_src, reg_write, ir_load, pc_write, illegal;
  logic [1:0]  alu_op, reg_src;

  int nchk = 0;
  int nerr = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  ucseq_top dut (
    .clk(clk), .rst(rst), .halt(halt), .opcode(opcode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upc(upc), .mem_write(mem_write), .mem_addr_sel(mem_addr_sel),
    .alu_src(alu_src), .alu_op(alu_op), .reg_src(reg_src),
    .reg_write(reg_write), .ir_load(ir_load), .pc_write(pc_write),
    .illegal(illegal)
  );

  function automatic logic [9:0] mk(logic pcw, logic irl, logic rw, logic [1:0] rs,
                                    logic [1:0] ao, logic as, logic mas, logic mw);
    return {pcw, irl, rw, rs, ao, as, mas, mw};
  endfunction

  function automatic logic [15:0] observed();
    return {upc, pc_write, ir_load, reg_write, reg_src, alu_op, alu_src,
            mem_addr_sel, mem_write, illegal};
  endfunction

  task automatic check(logic [15:0] act, logic [15:0] exp, string t);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic push(logic [4:0] u, logic [9:0] c, logic ill, string t);
    exp_q.push_back({u, c, ill});
    tag_q.push_back(t);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic start(logic [3:0] op);
    opcode = op;
    push(5'd0, mk(1,1,0,2'd0,2'd0,0,0,0), 1'b0, "R11 fetch");
    push(5'd1, mk(0,0,0,2'd0,2'd0,0,0,0), 1'b0, "R4 decode");
  endtask

  // monitor: one scoreboard item per rising edge, sampled off the edge
  always begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(observed(), e, t);
    end
  end

  initial begin
    #(8 * 20000);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(observed(), 16'h0000, "R1 reset state");
    rst = 1'b0;

    // R7 add
    start(4'd0);
    push(5'd2, mk(0,0,0,2'd0,2'd0,0,0,0), 1'b0, "R7 add exec");
    push(5'd3, mk(0,0,1,2'd0,2'd0,0,0,0), 1'b0, "R7 add writeback");
    drain();
    // R7 sub
    start(4'd1);
    push(5'd4, mk(0,0,0,2'd0,2'd1,0,0,0), 1'b0, "R7 sub exec");
    push(5'd5, mk(0,0,1,2'd0,2'd0,0,0,0), 1'b0, "R7 sub writeback");
    drain();
    // R8 load
    start(4'd2);
    push(5'd6, mk(0,0,0,2'd0,2'd0,1,0,0), 1'b0, "R8 load address");
    push(5'd7, mk(0,0,0,2'd0,2'd0,0,1,0), 1'b0, "R8 load read");
    push(5'd8, mk(0,0,1,2'd1,2'd0,0,0,0), 1'b0, "R8 load writeback");
    drain();
    // R9 store
    start(4'd3);
    push(5'd9,  mk(0,0,0,2'd0,2'd0,1,0,0), 1'b0, "R9 store address");
    push(5'd10, mk(0,0,0,2'd0,2'd0,0,1,1), 1'b0, "R9 store write");
    drain();
    // R10 branch and jump
    start(4'd4);
    push(5'd11, mk(1,0,0,2'd0,2'd1,0,0,0), 1'b0, "R10 branch exec");
    drain();
    start(4'd5);
    push(5'd12, mk(1,0,0,2'd0,2'd2,0,0,0), 1'b0, "R10 jump exec");
    drain();
    // R13 write attempt while running must be ignored
    start(4'd0);
    wr_en = 1'b1; wr_addr = 6'd2; wr_data = 12'hFF0;
    push(5'd2, mk(0,0,0,2'd0,2'd0,0,0,0), 1'b0, "R2 add exec");
    push(5'd3, mk(0,0,1,2'd0,2'd0,0,0,0), 1'b0, "R2 add writeback");
    drain();
    wr_en = 1'b0;
    start(4'd0);
    push(5'd2, mk(0,0,0,2'd0,2'd0,0,0,0), 1'b0, "R13 running write ignored");
    push(5'd3, mk(0,0,1,2'd0,2'd0,0,0,0), 1'b0, "R3 add writeback");
    drain();
    // R6 unmapped opcode
    start(4'd7);
    push(5'd0, mk(1,1,0,2'd0,2'd0,0,0,0), 1'b1, "R6 illegal fetch");
    drain();
    // R12 halt
    halt = 1'b1;
    push(5'd0, 10'd0, 1'b0, "R12 halted");
    push(5'd0, 10'd0, 1'b0, "R12 halted hold");
    push(5'd0, 10'd0, 1'b0, "R12 halted hold");
    drain();
    // R13 writes while halted
    wr_en = 1'b1; wr_addr = 6'd2; wr_data = 12'h070;
    @(negedge clk);
    wr_addr = 6'b100110; wr_data = 12'h02B;
    @(negedge clk);
    wr_addr = 6'b100101; wr_data = 12'h000;
    @(negedge clk);
    wr_en = 1'b0;
    halt = 1'b0;
    // R13 modified add exec step
    start(4'd0);
    push(5'd2, mk(0,0,0,2'd0,2'd3,1,0,0), 1'b0, "R13 rewritten step");
    push(5'd3, mk(0,0,1,2'd0,2'd0,0,0,0), 1'b0, "R5 add writeback");
    drain();
    // R13 new dispatch entry for opcode 6
    start(4'd6);
    push(5'd11, mk(1,0,0,2'd0,2'd1,0,0,0), 1'b0, "R13 new opcode");
    drain();
    // R13 retired opcode 5 now illegal
    start(4'd5);
    push(5'd0, mk(1,1,0,2'd0,2'd0,0,0,0), 1'b1, "R13 retired opcode");
    drain();

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule